// File: doc/BRIEF.md
# Atomic Sequence Permission Tracker

This block groups retired speculative stores into atomic sequences while their write permissions are still outstanding. It holds a small table of sequence slots, allocated in age order. Each slot counts the distinct cache lines its stores have written and the write permissions that have arrived for those lines. A slot is in one of three live states: accumulating stores, closed and waiting for permissions, or committing. The block decides when a sequence opens, when it closes, when the oldest one may commit, and which sequences a violation throws away.

A store retire is offered on the store port with its line index and a flag that marks the first speculative write to that line. A store that finds no accumulating sequence opens a new one. A per-line, per-sequence ownership bit array records which sequence first wrote each line, so a permission that names only a line can be credited to the right sequence. Register checkpoints and cache data paths sit outside. The block drives only the commit pulse, the ownership-clear mask, the hold for remote agents, and the rollback mask.

Top module: `asq_tracker`

## Requirements
- R1: After reset no commit or rollback is signalled, `st_ready` is 1 and `st_seq` is 0.
- R2: A store accepted while no sequence is accumulating opens the slot that follows the youngest live slot in age order (slot 0 after reset). `st_seq` gives the slot the store joins.
- R3: The line count of a sequence grows only for stores with `st_first` = 1. Stores with `st_first` = 0 join the sequence without adding to the count.
- R4: When an accumulating sequence reaches 16 counted lines it closes. The next store opens a new sequence.
- R5: A permission for a line adds one to the permission count of the live sequence that owns that line. A permission for a line that no live sequence owns has no effect.
- R6: When the oldest sequence has as many permissions as lines, it commits. Two clock edges after the permission that completes it, `commit_valid` and `hold_remote` are high for exactly one cycle. In that cycle `commit_seq` is the slot and `spec_clr_mask` is one-hot on that slot; otherwise both are zero.
- R7: A sequence that is still accumulating may commit directly. In the cycle it is found eligible, `st_ready` is 0. The next store then opens a new sequence.
- R8: Commits are strictly oldest first. A younger sequence that is complete waits until all older ones have committed, so successive commits carry consecutive slot numbers modulo 4.
- R9: When all 4 slots are live and a store would need a new sequence, `st_ready` is 0.
- R10: A violation on a live, non-committing slot discards that slot and every younger one. In the next cycle `rb_valid` is 1 and bit i of `rb_mask` is set for each discarded slot i. The next new sequence reuses the violated slot number. A violation on a free or committing slot is ignored. `st_ready` is 0 while `viol_valid` is high.
- R11: A discarded sequence loses ownership of its lines. A later permission for such a line is not credited to a new sequence that reuses the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Speculative store retire offered |
| st_line | input | 8 | Cache line index of the store |
| st_first | input | 1 | First speculative write to this line |
| st_ready | output | 1 | Store accepted this cycle |
| st_seq | output | 2 | Slot the offered store joins or opens |
| perm_valid | input | 1 | Write permission arrived |
| perm_line | input | 8 | Line the permission is for |
| viol_valid | input | 1 | Atomicity violation reported |
| viol_seq | input | 2 | Slot hit by the violation |
| commit_valid | output | 1 | Sequence commits this cycle |
| commit_seq | output | 2 | Committing slot |
| spec_clr_mask | output | 4 | One-hot clear for the committing slot's speculative bits |
| hold_remote | output | 1 | Stall memory requests from other agents |
| rb_valid | output | 1 | Rollback issued |
| rb_mask | output | 4 | Slots discarded by the rollback |

## Verification
The hardest state to reach is a full table: four live slots with a fifth sequence needed. A rollback is then made to free a slot in the middle of the age order, and that slot number is reused while a stale permission for a discarded line is still in flight. The stimulus closes four sequences of 16 lines each and offers one more store that must stall. It then rolls back from the second-oldest slot. A new sequence is opened in that slot, and a permission for a line that the discarded owner held is sent before the real one. A younger sequence that completes first is also held behind an older one, to expose any ordering breach.

// File: rtl/asq_pkg.sv
package asq_pkg;
  typedef enum logic [1:0] {
    SQ_FREE   = 2'd0,
    SQ_ACCUM  = 2'd1,
    SQ_AWAIT  = 2'd2,
    SQ_COMMIT = 2'd3
  } sq_state_e;
endpackage

// File: rtl/asq_slot.sv
// One sequence slot: state plus line and permission counters.
module asq_slot
  import asq_pkg::*;
#(
  parameter int CLOSE_LINES = 16,
  localparam int LCW = $clog2(CLOSE_LINES + 1)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      alloc_i,
  input  logic      alloc_first_i,
  input  logic      add_line_i,
  input  logic      perm_inc_i,
  input  logic      commit_i,
  input  logic      release_i,
  output sq_state_e state_o,
  output logic      eligible_o
);
  sq_state_e      state_q;
  logic [LCW-1:0] lines_q, filled_q;

  always_ff @(posedge clk) begin
    if (rst || release_i) begin
      state_q  <= SQ_FREE;
      lines_q  <= '0;
      filled_q <= '0;
    end else if (alloc_i) begin
      state_q  <= SQ_ACCUM;
      lines_q  <= LCW'(alloc_first_i);
      filled_q <= '0;
    end else begin
      if (commit_i) begin
        state_q <= SQ_COMMIT;
      end else if (add_line_i && state_q == SQ_ACCUM) begin
        lines_q <= lines_q + LCW'(1);
        if (lines_q == LCW'(CLOSE_LINES - 1)) state_q <= SQ_AWAIT;
      end
      if (perm_inc_i) filled_q <= filled_q + LCW'(1);
    end
  end

  assign state_o    = state_q;
  assign eligible_o = (state_q == SQ_ACCUM || state_q == SQ_AWAIT) && (filled_q == lines_q);
endmodule

// File: rtl/asq_spec_bits.sv
// Per-line ownership bits, one column per sequence slot, with column flash clear.
module asq_spec_bits #(
  parameter int NUM_LINES = 256,
  parameter int NUM_SEQ   = 4,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int SEQ_W  = $clog2(NUM_SEQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_i,
  input  logic [LINE_W-1:0]  set_line_i,
  input  logic [SEQ_W-1:0]   set_seq_i,
  input  logic [NUM_SEQ-1:0] clr_mask_i,
  input  logic [LINE_W-1:0]  rd_line_i,
  output logic [NUM_SEQ-1:0] rd_owner_o
);
  logic [NUM_SEQ-1:0] bits_q [NUM_LINES];
  logic [NUM_SEQ-1:0] set_onehot;

  assign set_onehot = NUM_SEQ'(1) << set_seq_i;

  always_ff @(posedge clk) begin
    for (int l = 0; l < NUM_LINES; l++) begin
      if (rst) bits_q[l] <= '0;
      else bits_q[l] <= (bits_q[l] & ~clr_mask_i) |
                        ((set_i && set_line_i == LINE_W'(l)) ? set_onehot : '0);
    end
  end

  assign rd_owner_o = bits_q[rd_line_i];
endmodule

// File: rtl/asq_tracker.sv
// Atomic sequence table: allocation, closing, oldest-first commit, rollback.
// NUM_SEQ must be a power of two (slot pointers wrap).
module asq_tracker
  import asq_pkg::*;
#(
  parameter int NUM_SEQ     = 4,
  parameter int CLOSE_LINES = 16,
  parameter int NUM_LINES   = 256,
  localparam int SEQ_W  = $clog2(NUM_SEQ),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               st_valid,
  input  logic [LINE_W-1:0]  st_line,
  input  logic               st_first,
  output logic               st_ready,
  output logic [SEQ_W-1:0]   st_seq,
  input  logic               perm_valid,
  input  logic [LINE_W-1:0]  perm_line,
  input  logic               viol_valid,
  input  logic [SEQ_W-1:0]   viol_seq,
  output logic               commit_valid,
  output logic [SEQ_W-1:0]   commit_seq,
  output logic [NUM_SEQ-1:0] spec_clr_mask,
  output logic               hold_remote,
  output logic               rb_valid,
  output logic [NUM_SEQ-1:0] rb_mask
);
  logic [SEQ_W-1:0]   head_q, tail_q, open_slot, age_v, age_s;
  sq_state_e          slot_st [NUM_SEQ];
  logic [NUM_SEQ-1:0] elig, busy, discard, release_v, perm_inc, alloc_v, add_v, commit_v, owners;
  logic               open_ok, head_elig, head_done, viol_ok, st_fire, go_commit, full;

  always_comb begin
    open_slot = tail_q - SEQ_W'(1);
    open_ok   = (slot_st[open_slot] == SQ_ACCUM);
    head_elig = elig[head_q];
    head_done = (slot_st[head_q] == SQ_COMMIT);
    full      = &busy;
    viol_ok   = viol_valid && busy[viol_seq] && (slot_st[viol_seq] != SQ_COMMIT);
    age_v     = viol_seq - head_q;
    go_commit = head_elig && !(viol_ok && age_v == '0);
    st_ready  = !viol_valid && (open_ok ? !(open_slot == head_q && head_elig) : !full);
    st_seq    = open_ok ? open_slot : tail_q;
    st_fire   = st_valid && st_ready;
    age_s     = '0;
    for (int s = 0; s < NUM_SEQ; s++) begin
      age_s        = SEQ_W'(s) - head_q;
      discard[s]   = viol_ok && busy[s] && (age_s >= age_v);
      release_v[s] = discard[s] || (head_done && head_q == SEQ_W'(s));
      perm_inc[s]  = perm_valid && owners[s] && !discard[s] &&
                     (slot_st[s] == SQ_ACCUM || slot_st[s] == SQ_AWAIT);
      alloc_v[s]   = st_fire && !open_ok && tail_q == SEQ_W'(s);
      add_v[s]     = st_fire && open_ok && st_first && open_slot == SEQ_W'(s);
      commit_v[s]  = go_commit && head_q == SEQ_W'(s);
    end
  end

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_slot
    asq_slot #(.CLOSE_LINES(CLOSE_LINES)) u_slot (
      .clk          (clk),
      .rst          (rst),
      .alloc_i      (alloc_v[g]),
      .alloc_first_i(st_first),
      .add_line_i   (add_v[g]),
      .perm_inc_i   (perm_inc[g]),
      .commit_i     (commit_v[g]),
      .release_i    (release_v[g]),
      .state_o      (slot_st[g]),
      .eligible_o   (elig[g])
    );
    assign busy[g] = (slot_st[g] != SQ_FREE);
  end

  asq_spec_bits #(.NUM_LINES(NUM_LINES), .NUM_SEQ(NUM_SEQ)) u_bits (
    .clk       (clk),
    .rst       (rst),
    .set_i     (st_fire && st_first),
    .set_line_i(st_line),
    .set_seq_i (st_seq),
    .clr_mask_i(release_v),
    .rd_line_i (perm_line),
    .rd_owner_o(owners)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q        <= '0;
      tail_q        <= '0;
      commit_valid  <= 1'b0;
      commit_seq    <= '0;
      spec_clr_mask <= '0;
      hold_remote   <= 1'b0;
      rb_valid      <= 1'b0;
      rb_mask       <= '0;
    end else begin
      head_q        <= head_q + SEQ_W'(head_done);
      tail_q        <= viol_ok ? viol_seq : tail_q + SEQ_W'(st_fire && !open_ok);
      commit_valid  <= go_commit;
      commit_seq    <= go_commit ? head_q : '0;
      spec_clr_mask <= go_commit ? (NUM_SEQ'(1) << head_q) : '0;
      hold_remote   <= go_commit;
      rb_valid      <= viol_ok;
      rb_mask       <= discard;
    end
  end
endmodule

// File: rtl/asq_tracker_chk.sv
module asq_tracker_chk #(
  parameter int NUM_SEQ = 4,
  localparam int SEQ_W = $clog2(NUM_SEQ)
) (
  input logic               clk,
  input logic               rst,
  input logic               st_ready,
  input logic               viol_valid,
  input logic [SEQ_W-1:0]   viol_seq,
  input logic               commit_valid,
  input logic [SEQ_W-1:0]   commit_seq,
  input logic [NUM_SEQ-1:0] spec_clr_mask,
  input logic               hold_remote,
  input logic               rb_valid,
  input logic [NUM_SEQ-1:0] rb_mask
);
  logic             seen_q;
  logic [SEQ_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (commit_valid) begin
      seen_q <= 1'b1;
      last_q <= commit_seq;
    end
  end

  assert_clr_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    commit_valid |-> (spec_clr_mask == (NUM_SEQ'(1) << commit_seq)) && hold_remote);
  assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !commit_valid |-> (spec_clr_mask == '0) && !hold_remote);
  assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    commit_valid |=> !commit_valid);
  assert_oldest_first_R8: assert property (@(posedge clk) disable iff (rst)
    (commit_valid && seen_q) |-> commit_seq == last_q + SEQ_W'(1));
  assert_viol_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> !st_ready);
  assert_rb_target_R10: assert property (@(posedge clk) disable iff (rst)
    rb_valid |-> rb_mask[$past(viol_seq)]);
  assert_rb_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !rb_valid |-> rb_mask == '0);
endmodule

bind asq_tracker asq_tracker_chk #(.NUM_SEQ(NUM_SEQ)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .st_ready     (st_ready),
  .viol_valid   (viol_valid),
  .viol_seq     (viol_seq),
  .commit_valid (commit_valid),
  .commit_seq   (commit_seq),
  .spec_clr_mask(spec_clr_mask),
  .hold_remote  (hold_remote),
  .rb_valid     (rb_valid),
  .rb_mask      (rb_mask)
);

// File: tb/tb_asq_tracker.sv
module tb_asq_tracker;
  localparam int CLK_P = 10;
  localparam int NSEQ  = 4;
  localparam int CLOSE = 16;
  localparam int NLN   = 256;

  logic       clk = 1'b0, rst = 1'b1;
  logic       st_valid = 0, st_first = 0, perm_valid = 0, viol_valid = 0;
  logic [7:0] st_line = 0, perm_line = 0;
  logic [1:0] viol_seq = 0;
  logic       st_ready, commit_valid, hold_remote, rb_valid;
  logic [1:0] st_seq, commit_seq;
  logic [3:0] spec_clr_mask, rb_mask;

  always #(CLK_P/2) clk = ~clk;

  asq_tracker dut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_line(st_line), .st_first(st_first),
    .st_ready(st_ready), .st_seq(st_seq), .perm_valid(perm_valid), .perm_line(perm_line),
    .viol_valid(viol_valid), .viol_seq(viol_seq), .commit_valid(commit_valid),
    .commit_seq(commit_seq), .spec_clr_mask(spec_clr_mask), .hold_remote(hold_remote),
    .rb_valid(rb_valid), .rb_mask(rb_mask)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  task automatic chk(int act, int exp, string req, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: list of live sequences, oldest first.
  typedef struct { int id; int st; int lines; int filled; } mseq_t;  // st: 0 accum, 1 await, 2 commit
  mseq_t mq[$];
  int owner[NLN];
  int next_id = 0;
  int m_cv = 0, m_cseq = 0, m_rbv = 0, m_rbm = 0;

  function automatic bit m_open();
    return mq.size() > 0 && mq[mq.size()-1].st == 0;
  endfunction
  function automatic bit m_elig(int i);
    return (mq[i].st == 0 || mq[i].st == 1) && mq[i].filled == mq[i].lines;
  endfunction
  function automatic bit m_ready();
    if (viol_valid) return 0;
    if (m_open()) return !(mq.size() == 1 && m_elig(0));
    return mq.size() < NSEQ;
  endfunction
  function automatic int m_seq();
    return m_open() ? mq[mq.size()-1].id : next_id;
  endfunction
  function automatic void drop_owner(int id);
    for (int l = 0; l < NLN; l++) if (owner[l] == id) owner[l] = -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      for (int l = 0; l < NLN; l++) owner[l] = -1;
      next_id = 0; m_cv = 0; m_cseq = 0; m_rbv = 0; m_rbm = 0;
    end else begin
      automatic bit rdy = m_ready();
      automatic bit opn = m_open();
      automatic int sz = mq.size();
      automatic int k = -1;
      automatic bit hd = sz > 0 && mq[0].st == 2;
      automatic bit go;
      automatic int lim;
      if (viol_valid)
        for (int i = 0; i < sz; i++) if (mq[i].id == viol_seq && mq[i].st != 2) k = i;
      go = sz > 0 && m_elig(0) && k != 0;
      m_cv = go; m_cseq = go ? mq[0].id : 0;
      m_rbv = (k >= 0); m_rbm = 0;
      lim = (k >= 0) ? k : sz;
      if (perm_valid && owner[perm_line] >= 0)
        for (int i = 0; i < lim; i++)
          if (mq[i].id == owner[perm_line] && (mq[i].st == 0 || mq[i].st == 1)) mq[i].filled++;
      if (st_valid && rdy) begin
        if (opn) begin
          if (st_first) begin
            mq[sz-1].lines++;
            owner[st_line] = mq[sz-1].id;
            if (mq[sz-1].lines == CLOSE) mq[sz-1].st = 1;
          end
        end else begin
          mq.push_back('{id: next_id, st: 0, lines: st_first ? 1 : 0, filled: 0});
          if (st_first) owner[st_line] = next_id;
          next_id = (next_id + 1) % NSEQ;
        end
      end
      if (go) mq[0].st = 2;
      if (k >= 0) begin
        for (int i = sz - 1; i >= k; i--) begin
          m_rbm |= (1 << mq[i].id);
          drop_owner(mq[i].id);
          mq.delete(i);
        end
        next_id = viol_seq;
      end
      if (hd) begin
        drop_owner(mq[0].id);
        void'(mq.pop_front());
      end
    end
  end

  task automatic compare_all();
    chk(st_ready, m_ready(), cur_req, "st_ready");
    chk(st_seq, m_seq(), cur_req, "st_seq");
    chk(commit_valid, m_cv, cur_req, "commit_valid");
    chk(commit_seq, m_cseq, cur_req, "commit_seq");
    chk(spec_clr_mask, m_cv ? (1 << m_cseq) : 0, cur_req, "spec_clr_mask");
    chk(hold_remote, m_cv, cur_req, "hold_remote");
    chk(rb_valid, m_rbv, cur_req, "rb_valid");
    chk(rb_mask, m_rbm, cur_req, "rb_mask");
  endtask

  task automatic drive(bit sv, int ln, bit fi, bit pv, int pl, bit vv, int vs);
    @(negedge clk);
    st_valid = sv; st_line = 8'(ln); st_first = fi;
    perm_valid = pv; perm_line = 8'(pl);
    viol_valid = vv; viol_seq = 2'(vs);
    #1;
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic store(int ln, bit fi);
    for (int t = 0; t < 50; t++) begin
      drive(1, ln, fi, 0, 0, 0, 0);
      if (st_ready) return;
    end
    chk(0, 1, cur_req, "store never accepted");
  endtask

  task automatic perm(int pl);
    drive(0, 0, 0, 1, pl, 0, 0);
  endtask

  task automatic wait_commit(int exp_seq, string req);
    for (int t = 0; t < 40; t++) begin
      idle(1);
      if (commit_valid) begin
        chk(commit_seq, exp_seq, req, "committed slot");
        return;
      end
    end
    chk(0, 1, req, "commit never seen");
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state
    cur_req = "R1";
    idle(1);
    chk(st_ready, 1, "R1", "st_ready after reset");
    chk(st_seq, 0, "R1", "st_seq after reset");
    chk(commit_valid, 0, "R1", "commit_valid after reset");
    chk(rb_valid, 0, "R1", "rb_valid after reset");

    // R2, R3: open slot 0, repeat store to a line is not counted
    cur_req = "R2";
    store(1, 1);
    chk(st_seq, 0, "R2", "first sequence slot");
    cur_req = "R3";
    store(1, 0);
    store(2, 1);
    perm(1);
    idle(3);
    chk(commit_valid, 0, "R3", "no commit with one of two permissions");
    // R7: direct commit from accumulate
    cur_req = "R7";
    perm(2);
    drive(1, 5, 1, 0, 0, 0, 0);
    chk(st_ready, 0, "R7", "store blocked while open sequence is eligible");
    idle(1);
    chk(commit_valid, 1, "R6", "commit two edges after completing permission");
    chk(commit_seq, 0, "R6", "commit slot");
    chk(spec_clr_mask, 1, "R6", "clear mask");
    chk(hold_remote, 1, "R6", "remote hold");
    store(5, 1);
    chk(st_seq, 1, "R7", "new sequence after direct commit");

    // R4: close at 16 lines
    cur_req = "R4";
    for (int l = 10; l < 25; l++) store(l, 1);
    store(30, 1);
    chk(st_seq, 2, "R4", "new sequence after 16 lines");
    cur_req = "R6";
    perm(5);
    for (int l = 10; l < 25; l++) perm(l);
    wait_commit(1, "R6");

    // R8: younger complete sequence waits for older
    cur_req = "R8";
    for (int l = 31; l < 46; l++) store(l, 1);
    store(50, 1);
    chk(st_seq, 3, "R8", "younger sequence slot");
    perm(50);
    idle(4);
    chk(commit_valid, 0, "R8", "younger must not commit first");
    for (int l = 30; l < 45; l++) perm(l);
    cur_req = "R5";
    perm(200);
    idle(3);
    chk(commit_valid, 0, "R5", "unowned permission ignored");
    cur_req = "R8";
    perm(45);
    wait_commit(2, "R8");
    wait_commit(3, "R8");

    // R9: table full
    cur_req = "R9";
    for (int l = 60; l < 124; l++) store(l, 1);
    for (int i = 0; i < 3; i++) begin
      drive(1, 124, 1, 0, 0, 0, 0);
      chk(st_ready, 0, "R9", "store stalled with all slots live");
    end
    // R10: rollback from slot 1
    cur_req = "R10";
    drive(0, 0, 0, 0, 0, 1, 1);
    chk(st_ready, 0, "R10", "store blocked during violation");
    idle(1);
    chk(rb_valid, 1, "R10", "rollback pulse");
    chk(rb_mask, 4'b1110, "R10", "discarded slots");
    store(130, 1);
    chk(st_seq, 1, "R10", "reuse violated slot");
    // R11: stale permission for a line of a discarded sequence
    cur_req = "R11";
    perm(80);
    for (int l = 60; l < 76; l++) perm(l);
    wait_commit(0, "R11");
    idle(3);
    chk(commit_valid, 0, "R11", "stale permission not credited");
    perm(130);
    wait_commit(1, "R11");
    // R10: violation on a free slot is ignored
    cur_req = "R10";
    drive(0, 0, 0, 0, 0, 1, 3);
    idle(1);
    chk(rb_valid, 0, "R10", "violation on free slot ignored");
    idle(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule